// File: doc/BRIEF.md
# Gear-Controlled Timer Prescaler

This block produces the clock-enable strobes that pace a bank of 8-bit timers. The input that paces the prescaler comes from one of three places: the fast main clock after a selectable gear divide, the fast main clock after a fixed divide by 16, or a slow sub-clock. The slow sub-clock arrives as a single-cycle enable input in the one synchronous clock domain. A single free-running counter advances once per pulse of that input and yields four tick outputs, each one clock wide: the base tick and three slower ticks derived from it.

The configuration arrives as plain inputs: a system-clock select bit, a 3-bit gear code and a 2-bit source code. The block latches a new selection only at a boundary of the divided clock, so a tick is never cut short when the selection changes. A synchronous reset clears the whole divider chain.

Top module: `gear_prescaler`

## Requirements
- R1: With `sys_sel` = 1 the prescaler advances exactly on cycles where `slow_en` is 1. `gear` and `src_sel` have no effect in this mode.
- R2: With `sys_sel` = 0 and `src_sel` = 00, gear codes 0, 1, 2, 3 and 4 advance the prescaler once every 1, 2, 4, 8 and 16 clock cycles.
- R3: With `sys_sel` = 0 and `src_sel` = 10, the prescaler advances once every 16 clock cycles whatever the value of `gear`.
- R4: `tick_t1` is a one-cycle pulse on every 8th prescaler advance, so a tick is never followed by another tick in the next cycle.
- R5: `tick_t4` pulses on every 4th `tick_t1`, and `tick_t16` pulses on every 16th `tick_t1`. Each of these pulses falls in the same cycle as a `tick_t1`.
- R6: `tick_t256` pulses on every 256th `tick_t1`, in the same cycle as a `tick_t16`.
- R7: Gear codes 5, 6 and 7 behave as gear code 4 (divide by 16).
- R8: Source codes 01 and 11 behave as source code 00.
- R9: While `rst` is 1 the divider chain is cleared and every tick output is 0. No tick appears in the first cycle after `rst` falls. The first `tick_t1` then comes on the 8th prescaler advance.
- R10: A change of `sys_sel`, `gear` or `src_sel` takes effect at the next prescaler advance under the old selection. The advance interval in force until then is never shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main fast clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_en | input | 1 | One-cycle enable marking each sub-clock period |
| sys_sel | input | 1 | 1 selects the sub-clock as prescaler input |
| gear | input | 3 | Fast-clock gear divide code |
| src_sel | input | 2 | Prescaler source: 10 is fast/16, other codes take the geared clock |
| tick_t1 | output | 1 | Base tick, one pulse per 8 prescaler input periods |
| tick_t4 | output | 1 | Tick at one quarter of the base rate |
| tick_t16 | output | 1 | Tick at one sixteenth of the base rate |
| tick_t256 | output | 1 | Tick at 1/256 of the base rate |

## Verification
Each gear code 0 to 4 is held long enough to measure the base tick gap, which must come out as 8, 16, 32, 64 and 128 cycles. A wrong divide in any one gear therefore shows up on its own. The reserved gear codes and the reserved source codes are tried with settings whose gap differs from the one they must copy, which separates correct aliasing from a fall-through to another code. The fixed fast/16 source and the sub-clock mode are each run with two different gear values, which shows that the gear has no effect there. Mid-interval changes between fast and slow gears and modes, checked cycle by cycle against a behavioural model, separate boundary-aligned switching from immediate switching.

// File: rtl/gear_prescaler.sv
module gear_prescaler #(
  parameter int T1_SHIFT = 3,
  parameter int MAX_GEAR_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slow_en,
  input  logic       sys_sel,
  input  logic [2:0] gear,
  input  logic [1:0] src_sel,
  output logic       tick_t1,
  output logic       tick_t4,
  output logic       tick_t16,
  output logic       tick_t256
);

  localparam int PW = T1_SHIFT + 8;
  localparam int DW = MAX_GEAR_LOG2;
  localparam int AW = $clog2(MAX_GEAR_LOG2 + 1);

  logic [AW-1:0] req_log2, act_log2;
  logic          act_slow;
  logic [DW-1:0] div_cnt, div_mask;
  logic [PW-1:0] pre_cnt;
  logic          pre_en, run;

  assign req_log2 = (src_sel == 2'b10 || int'(gear) >= MAX_GEAR_LOG2)
                    ? AW'(MAX_GEAR_LOG2) : AW'(gear);
  assign div_mask = DW'((32'd1 << act_log2) - 32'd1);
  assign pre_en   = act_slow ? slow_en : (div_cnt == div_mask);
  assign run      = !rst && pre_en;

  always_ff @(posedge clk) begin
    if (rst || pre_en) begin
      act_slow <= sys_sel;
      act_log2 <= req_log2;
    end
    if (rst || pre_en || act_slow) div_cnt <= '0;
    else                           div_cnt <= div_cnt + 1'b1;
    if (rst)         pre_cnt <= '0;
    else if (pre_en) pre_cnt <= pre_cnt + 1'b1;
  end

  assign tick_t1   = run && (&pre_cnt[T1_SHIFT-1:0]);
  assign tick_t4   = run && (&pre_cnt[T1_SHIFT+1:0]);
  assign tick_t16  = run && (&pre_cnt[T1_SHIFT+3:0]);
  assign tick_t256 = run && (&pre_cnt[PW-1:0]);

  a_r9_release_quiet: assert property (@(posedge clk)
    rst |=> !(tick_t1 || tick_t4 || tick_t16 || tick_t256));

  a_r4_t1_single: assert property (@(posedge clk) disable iff (rst)
    tick_t1 |=> !tick_t1);

  a_r5_t4_within_t1: assert property (@(posedge clk) disable iff (rst)
    (tick_t4 || tick_t16) |-> tick_t1);

  a_r6_t256_within_t16: assert property (@(posedge clk) disable iff (rst)
    tick_t256 |-> (tick_t16 && tick_t4));

  a_r1_slow_only_on_enable: assert property (@(posedge clk) disable iff (rst)
    (act_slow && !slow_en) |-> !tick_t1);

  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !pre_en |=> ($stable(act_log2) && $stable(act_slow)));

endmodule

// File: tb/gear_prescaler_tb_top.sv
module gear_prescaler_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_en = 1'b0;
  logic sys_sel = 1'b0;
  logic [2:0] gear = 3'd0;
  logic [1:0] src_sel = 2'd0;
  logic t1, t4, t16, t256;

  int checks = 0, errors = 0;
  int cyc_no = 0, slow_period = 0;
  int m_slow = 0, m_n = 1, m_d = 0, m_p = 0;
  int last_t1 = 0, last_gap = 0, t1_seen = 0;
  int c1, c4, c16, c256;
  bit done = 0;
  string tag = "R9";

  always #2 clk = ~clk;

  gear_prescaler dut_i (
    .clk(clk), .rst(rst), .slow_en(slow_en), .sys_sel(sys_sel),
    .gear(gear), .src_sel(src_sel),
    .tick_t1(t1), .tick_t4(t4), .tick_t16(t16), .tick_t256(t256)
  );

  function automatic int wanted_n();
    if (src_sel == 2'b10 || gear >= 3'd4) return 16;
    return 1 << gear;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    bit pre, e1, e4, e16, e256;
    slow_en = (slow_period > 0) && (cyc_no % slow_period == 0);
    #1;
    pre  = (m_slow != 0) ? slow_en : (m_d == m_n - 1);
    e1   = !rst && pre && (m_p % 8 == 7);
    e4   = !rst && pre && (m_p % 32 == 31);
    e16  = !rst && pre && (m_p % 128 == 127);
    e256 = !rst && pre && (m_p % 2048 == 2047);
    check(t1 == e1, tag, "R4 tick_t1", t1, e1);
    check(t4 == e4, tag, "R5 tick_t4", t4, e4);
    check(t16 == e16, tag, "R5 tick_t16", t16, e16);
    check(t256 == e256, tag, "R6 tick_t256", t256, e256);
    if (t1) begin
      last_gap = cyc_no - last_t1;
      last_t1 = cyc_no;
      t1_seen++;
    end
    c1 += int'(t1); c4 += int'(t4); c16 += int'(t16); c256 += int'(t256);
    if (rst || pre) begin
      m_slow = int'(sys_sel);
      m_n = wanted_n();
      m_d = 0;
      m_p = rst ? 0 : (m_p + 1) % 2048;
    end else if (m_slow == 0) begin
      m_d++;
    end
    cyc_no++;
    @(negedge clk);
  endtask

  task automatic expect_gap(int n, string req);
    int s;
    tag = req;
    s = t1_seen;
    while (t1_seen < s + 3) cyc();
    check(last_gap == n, req, "tick_t1 gap", last_gap, n);
  endtask

  task automatic set_cfg(bit s, int g, int src);
    sys_sel = s;
    gear = 3'(g);
    src_sel = 2'(src);
  endtask

  initial begin
    @(negedge clk);
    tag = "R9";
    for (int i = 0; i < 3; i++) cyc();
    rst = 1'b0;
    #1;
    check(!(t1 || t4 || t16 || t256), "R9", "ticks in release cycle", int'(t1), 0);
    #1; @(negedge clk);
    rst = 1'b1; cyc(); rst = 1'b0;
    c1 = 0; c4 = 0; c16 = 0; c256 = 0;
    tag = "R6";
    for (int i = 0; i < 2048; i++) cyc();
    check(c1 == 256, "R4", "t1 count over 2048", c1, 256);
    check(c4 == 64, "R5", "t4 count over 2048", c4, 64);
    check(c16 == 16, "R5", "t16 count over 2048", c16, 16);
    check(c256 == 1, "R6", "t256 count over 2048", c256, 1);

    set_cfg(0, 0, 0); expect_gap(8, "R2");
    set_cfg(0, 1, 0); expect_gap(16, "R2");
    set_cfg(0, 2, 0); expect_gap(32, "R2");
    set_cfg(0, 3, 0); expect_gap(64, "R2");
    set_cfg(0, 4, 0); expect_gap(128, "R2");
    set_cfg(0, 0, 0); expect_gap(8, "R2");
    set_cfg(0, 5, 0); expect_gap(128, "R7");
    set_cfg(0, 1, 0); expect_gap(16, "R7");
    set_cfg(0, 6, 0); expect_gap(128, "R7");
    set_cfg(0, 7, 0); expect_gap(128, "R7");
    set_cfg(0, 0, 2); expect_gap(128, "R3");
    set_cfg(0, 3, 2); expect_gap(128, "R3");
    set_cfg(0, 1, 1); expect_gap(16, "R8");
    set_cfg(0, 2, 3); expect_gap(32, "R8");
    set_cfg(0, 0, 1); expect_gap(8, "R8");
    slow_period = 3;
    set_cfg(1, 0, 0); expect_gap(24, "R1");
    set_cfg(1, 4, 2); expect_gap(24, "R1");
    slow_period = 5;
    set_cfg(1, 2, 0); expect_gap(40, "R1");

    tag = "R10";
    slow_period = 7;
    for (int k = 0; k < 12; k++) begin
      set_cfg(k % 3 == 0, (k * 5) % 8, (k % 4 == 1) ? 2 : 0);
      for (int i = 0; i < 37 + 11 * k; i++) cyc();
    end
    set_cfg(0, 4, 0);
    for (int i = 0; i < 50; i++) cyc();
    set_cfg(0, 0, 0);
    for (int i = 0; i < 200; i++) cyc();
    set_cfg(1, 0, 0);
    for (int i = 0; i < 100; i++) cyc();
    set_cfg(0, 1, 0);
    for (int i = 0; i < 100; i++) cyc();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc_no, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule